// File: doc/BRIEF.md
# Segment Access Privilege and Limit Checker

This block decides whether a segment-register load or a far control transfer may go ahead. A request gives the kind of operation, the current privilege level of the running code, the requested privilege level taken from the selector, and the already fetched target descriptor: its access byte, its 20-bit limit and its granularity flag. Gate-mediated transfers also give the gate's own privilege level. The operand or target offset is checked against the descriptor's scaled limit in the same cycle.

Presence, privilege, type and limit are each judged by a separate rule unit, and all four run in parallel. A priority encoder then reduces the four results to one fault code. The verdict is registered, so it appears one clock after the request together with a valid flag. Privilege levels run from 0, the most trusted, to 3, the least. A larger number means less privilege.

Top module: `seg_access_guard`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high, with its `grant` and `fault`, right after the next rising edge. With no request in the previous cycle, and during reset, `rsp_valid`, `grant` and `fault` are all zero.
- R2: `fault` codes are 0 none, 1 privilege, 2 type, 3 limit and 4 not-present. `grant` is 1 exactly when a valid response carries fault 0.
- R3: The access byte layout is bit 7 present, bits 6:5 DPL, bit 4 S (code/data), bit 3 E (executable), bit 2 conforming for code or expand-down for data, and bit 1 readable for code or writable for data. A clear present bit always gives fault 4.
- R4: For a data-register load (op 0), privilege passes only when DPL >= max(CPL, RPL).
- R5: For a stack load (op 1), privilege passes only when RPL == CPL. The target must be writable data (E=0, bit 1 set), or a type fault results.
- R6: For a direct far JMP (op 2) or far CALL (op 3), a nonconforming target needs DPL == CPL and a conforming target needs DPL <= CPL.
- R7: For a gate JMP (op 4) or gate CALL (op 5), max(CPL, RPL) must be <= the gate DPL. The destination DPL must equal CPL for a JMP and must be <= CPL for a CALL.
- R8: A type fault results when S=0, when a data load targets execute-only code, when any far transfer targets a data segment, or when the op code is 6 or 7.
- R9: The effective limit is the 20-bit limit when G=0. When G=1 it is the limit shifted left by 12 with the low 12 bits set. For code and expand-up data, an offset above the effective limit gives a limit fault.
- R10: For an expand-down data segment (E=0, bit 2 set), an offset at or below the effective limit gives a limit fault, and an offset above it passes.
- R11: When several rules fail together, the reported fault follows the order not-present, then privilege, then type, then limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation kind (0..5, 6 and 7 reserved) |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level from selector |
| gate_dpl | input | 2 | Privilege level of the gate descriptor |
| access | input | 8 | Target descriptor access byte |
| seg_limit | input | 20 | Target descriptor limit |
| seg_gran | input | 1 | Granularity: 1 scales limit to 4 KB units |
| offset | input | 32 | Operand or target offset |
| rsp_valid | output | 1 | Verdict valid |
| grant | output | 1 | Access permitted |
| fault | output | 3 | Fault reason code |

## Verification
The privilege, type and limit rules are evaluated in the same cycle, so one request can break more than one of them at once. The bench drives descriptors built to fail two rules together. Examples are a stack load with a mismatched RPL into read-only data, an execute-only code target with an offset past its limit, and a not-present descriptor that would also fail privilege. Each such request is judged by whether the single reported code is the higher-priority one.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    typedef enum logic [2:0] {
        OP_DATA_LD  = 3'd0,
        OP_STACK_LD = 3'd1,
        OP_FAR_JMP  = 3'd2,
        OP_FAR_CALL = 3'd3,
        OP_GATE_JMP = 3'd4,
        OP_GATE_CALL= 3'd5
    } op_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_PRIV   = 3'd1,
        FLT_TYPE   = 3'd2,
        FLT_LIMIT  = 3'd3,
        FLT_ABSENT = 3'd4
    } fault_e;

    // access byte, msb first
    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       s;
        logic       exec;
        logic       conf_ed;
        logic       rd_wr;
        logic       touched;
    } acc_t;

    typedef struct packed {
        logic       valid;
        logic       grant;
        fault_e     fault;
    } verdict_t;

endpackage

// File: rtl/seg_priv_rule.sv
module seg_priv_rule
    import seg_guard_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic [2:0]      op,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic [PL_W-1:0] gate_dpl,
    input  logic            conforming,
    output logic            priv_ok
);
    logic [PL_W-1:0] eff_pl;

    always_comb begin
        eff_pl = (cpl > rpl) ? cpl : rpl;
        case (op)
            OP_DATA_LD:   priv_ok = (dpl >= eff_pl);
            OP_STACK_LD:  priv_ok = (rpl == cpl);
            OP_FAR_JMP,
            OP_FAR_CALL:  priv_ok = conforming ? (dpl <= cpl) : (dpl == cpl);
            OP_GATE_JMP:  priv_ok = (eff_pl <= gate_dpl) && (dpl == cpl);
            OP_GATE_CALL: priv_ok = (eff_pl <= gate_dpl) && (dpl <= cpl);
            default:      priv_ok = 1'b1;   // reserved ops fault on type
        endcase
    end
endmodule

// File: rtl/seg_type_rule.sv
module seg_type_rule
    import seg_guard_pkg::*;
(
    input  logic [2:0] op,
    input  acc_t       acc,
    output logic       type_ok
);
    always_comb begin
        if (!acc.s) begin
            type_ok = 1'b0;
        end else begin
            case (op)
                OP_DATA_LD:   type_ok = acc.exec ? acc.rd_wr : 1'b1;
                OP_STACK_LD:  type_ok = !acc.exec && acc.rd_wr;
                OP_FAR_JMP,
                OP_FAR_CALL,
                OP_GATE_JMP,
                OP_GATE_CALL: type_ok = acc.exec;
                default:      type_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/seg_limit_rule.sv
module seg_limit_rule #(
    parameter int LIM_W      = 20,
    parameter int OFS_W      = 32,
    parameter int GRAN_SHIFT = 12
) (
    input  logic [LIM_W-1:0] seg_limit,
    input  logic             seg_gran,
    input  logic             expand_down,
    input  logic [OFS_W-1:0] offset,
    output logic             limit_ok
);
    localparam int EXT_W = LIM_W + GRAN_SHIFT;

    logic [EXT_W-1:0] scaled;
    logic [OFS_W-1:0] eff_limit;
    logic             above;

    always_comb begin
        scaled    = {seg_limit, {GRAN_SHIFT{1'b1}}};
        eff_limit = seg_gran ? OFS_W'(scaled) : OFS_W'(seg_limit);
        above     = (offset > eff_limit);
        limit_ok  = expand_down ? above : !above;
    end
endmodule

// File: rtl/seg_access_guard.sv
module seg_access_guard
    import seg_guard_pkg::*;
#(
    parameter int PL_W       = 2,
    parameter int LIM_W      = 20,
    parameter int OFS_W      = 32,
    parameter int GRAN_SHIFT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       op,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  rpl,
    input  logic [PL_W-1:0]  gate_dpl,
    input  logic [7:0]       access,
    input  logic [LIM_W-1:0] seg_limit,
    input  logic             seg_gran,
    input  logic [OFS_W-1:0] offset,
    output logic             rsp_valid,
    output logic             grant,
    output logic [2:0]       fault
);
    acc_t     acc;
    logic     priv_ok;
    logic     type_ok;
    logic     limit_ok;
    logic     exp_down;
    verdict_t st_d;
    verdict_t st_q;

    assign acc      = acc_t'(access);
    assign exp_down = acc.s && !acc.exec && acc.conf_ed;

    seg_priv_rule #(.PL_W(PL_W)) u_priv (
        .op         (op),
        .cpl        (cpl),
        .rpl        (rpl),
        .dpl        (PL_W'(acc.dpl)),
        .gate_dpl   (gate_dpl),
        .conforming (acc.exec && acc.conf_ed),
        .priv_ok    (priv_ok)
    );

    seg_type_rule u_type (
        .op      (op),
        .acc     (acc),
        .type_ok (type_ok)
    );

    seg_limit_rule #(
        .LIM_W      (LIM_W),
        .OFS_W      (OFS_W),
        .GRAN_SHIFT (GRAN_SHIFT)
    ) u_limit (
        .seg_limit   (seg_limit),
        .seg_gran    (seg_gran),
        .expand_down (exp_down),
        .offset      (offset),
        .limit_ok    (limit_ok)
    );

    always_comb begin
        st_d = '{valid: 1'b0, grant: 1'b0, fault: FLT_NONE};
        if (req_valid) begin
            st_d.valid = 1'b1;
            if (!acc.present)  st_d.fault = FLT_ABSENT;
            else if (!priv_ok) st_d.fault = FLT_PRIV;
            else if (!type_ok) st_d.fault = FLT_TYPE;
            else if (!limit_ok) st_d.fault = FLT_LIMIT;
            else               st_d.fault = FLT_NONE;
            st_d.grant = (st_d.fault == FLT_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{valid: 1'b0, grant: 1'b0, fault: FLT_NONE};
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign grant     = st_q.grant;
    assign fault     = st_q.fault;
endmodule

// File: rtl/seg_access_guard_chk.sv
module seg_access_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  op,
    input logic [1:0]  cpl,
    input logic [1:0]  rpl,
    input logic [7:0]  access,
    input logic        rsp_valid,
    input logic        grant,
    input logic [2:0]  fault
);
    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!grant && fault == 3'd0)); // R1
    AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (grant == (fault == 3'd0))); // R2
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (fault <= 3'd4)); // R2
    AST_ABSENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !access[7]) |=> (fault == 3'd4)); // R3
    AST_STACK_RPL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && access[7] && op == 3'd1 && rpl != cpl) |=> (fault == 3'd1)); // R5
endmodule

bind seg_access_guard seg_access_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op        (op),
    .cpl       (cpl),
    .rpl       (rpl),
    .access    (access),
    .rsp_valid (rsp_valid),
    .grant     (grant),
    .fault     (fault)
);

// File: tb/seg_access_guard_bench.sv
module seg_access_guard_bench;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  cpl;
        logic [1:0]  rpl;
        logic [1:0]  gdpl;
        logic [7:0]  acc;
        logic [19:0] lim;
        logic        g;
        logic [31:0] off;
        logic [2:0]  exp;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        // R4 data loads
        '{4'd4, 3'd0, 2'd3, 2'd3, 2'd0, 8'hF2, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        '{4'd4, 3'd0, 2'd0, 2'd3, 2'd0, 8'hB2, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        '{4'd4, 3'd0, 2'd2, 2'd0, 2'd0, 8'hD2, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        // R8 exec-only code into data reg; readable code passes
        '{4'd8, 3'd0, 2'd0, 2'd0, 2'd0, 8'h98, 20'hFFFFF, 1'b0, 32'h100, 3'd2},
        '{4'd8, 3'd0, 2'd0, 2'd0, 2'd0, 8'h9A, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        // R5 stack loads
        '{4'd5, 3'd1, 2'd1, 2'd1, 2'd0, 8'hB2, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        '{4'd5, 3'd1, 2'd1, 2'd2, 2'd0, 8'hB2, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        '{4'd5, 3'd1, 2'd0, 2'd0, 2'd0, 8'h90, 20'hFFFFF, 1'b0, 32'h100, 3'd2},
        // R6 direct transfers
        '{4'd6, 3'd2, 2'd2, 2'd2, 2'd0, 8'hDA, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        '{4'd6, 3'd3, 2'd2, 2'd2, 2'd0, 8'hBA, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        '{4'd6, 3'd3, 2'd2, 2'd2, 2'd0, 8'hBE, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        '{4'd6, 3'd2, 2'd1, 2'd1, 2'd0, 8'hDE, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        // R7 gate transfers
        '{4'd7, 3'd4, 2'd3, 2'd3, 2'd3, 8'hFA, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        '{4'd7, 3'd4, 2'd3, 2'd3, 2'd3, 8'h9A, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        '{4'd7, 3'd5, 2'd3, 2'd3, 2'd3, 8'h9A, 20'hFFFFF, 1'b0, 32'h100, 3'd0},
        '{4'd7, 3'd5, 2'd1, 2'd3, 2'd2, 8'h9A, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        // R8 type cases
        '{4'd8, 3'd2, 2'd0, 2'd0, 2'd0, 8'h92, 20'hFFFFF, 1'b0, 32'h100, 3'd2},
        '{4'd8, 3'd0, 2'd0, 2'd0, 2'd0, 8'h82, 20'hFFFFF, 1'b0, 32'h100, 3'd2},
        '{4'd8, 3'd6, 2'd0, 2'd0, 2'd0, 8'h92, 20'hFFFFF, 1'b0, 32'h100, 3'd2},
        // R9 limit and granularity
        '{4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 8'h92, 20'h00FFF, 1'b0, 32'h1000, 3'd3},
        '{4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 8'h92, 20'h00FFF, 1'b0, 32'hFFF, 3'd0},
        '{4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 8'h92, 20'h00001, 1'b1, 32'h1FFF, 3'd0},
        '{4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 8'h92, 20'h00001, 1'b1, 32'h2000, 3'd3},
        '{4'd9, 3'd0, 2'd0, 2'd0, 2'd0, 8'h92, 20'hFFFFF, 1'b1, 32'hFFFFFFFF, 3'd0},
        // R10 expand-down
        '{4'd10, 3'd0, 2'd0, 2'd0, 2'd0, 8'h96, 20'h00FFF, 1'b0, 32'hFFF, 3'd3},
        '{4'd10, 3'd0, 2'd0, 2'd0, 2'd0, 8'h96, 20'h00FFF, 1'b0, 32'h1000, 3'd0},
        // R3 not-present beats privilege; R11 priority pairs
        '{4'd3, 3'd0, 2'd3, 2'd3, 2'd0, 8'h12, 20'hFFFFF, 1'b0, 32'h100, 3'd4},
        '{4'd11, 3'd1, 2'd0, 2'd1, 2'd0, 8'h90, 20'hFFFFF, 1'b0, 32'h100, 3'd1},
        '{4'd11, 3'd0, 2'd0, 2'd0, 2'd0, 8'h98, 20'h00000, 1'b0, 32'h10, 3'd2},
        '{4'd11, 3'd0, 2'd3, 2'd3, 2'd0, 8'h92, 20'h00010, 1'b0, 32'h20, 3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  cpl = '0, rpl = '0, gate_dpl = '0;
    logic [7:0]  access = '0;
    logic [19:0] seg_limit = '0;
    logic        seg_gran = 1'b0;
    logic [31:0] offset = '0;
    logic        rsp_valid, grant;
    logic [2:0]  fault;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    seg_access_guard u_seg_access_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .cpl(cpl), .rpl(rpl), .gate_dpl(gate_dpl), .access(access),
        .seg_limit(seg_limit), .seg_gran(seg_gran), .offset(offset),
        .rsp_valid(rsp_valid), .grant(grant), .fault(fault)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        op = v.op; cpl = v.cpl; rpl = v.rpl; gate_dpl = v.gdpl;
        access = v.acc; seg_limit = v.lim; seg_gran = v.g; offset = v.off;
        req_valid = 1'b1;
    endtask

    task automatic judge(input vec_t v, input int idx);
        string t;
        t = $sformatf("R%0d vec%0d fault", v.req, idx);
        check(t, {5'd0, fault}, {5'd0, v.exp});
        // R2 grant matches fault
        check($sformatf("R2 vec%0d grant", idx), {7'd0, grant}, {7'd0, v.exp == 3'd0});
        check($sformatf("R1 vec%0d valid", idx), {7'd0, rsp_valid}, 8'd1);
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {7'd0, rsp_valid}, 8'd0);
        check("R1 reset grant", {7'd0, grant}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle fault", {5'd0, fault}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            req_valid = 1'b0;
            judge(VEC[i], i);
            @(negedge clk);
            // R1 quiet after a lone request
            check("R1 idle after req", {6'd0, rsp_valid, grant}, 8'd0);
        end

        // R1 back-to-back requests, one verdict per cycle
        drive(VEC[1]);
        @(negedge clk);
        judge(VEC[1], 1);
        drive(VEC[26]);
        @(negedge clk);
        judge(VEC[26], 26);
        drive(VEC[0]);
        @(negedge clk);
        req_valid = 1'b0;
        judge(VEC[0], 0);

        // R1 reset mid-stream clears the verdict
        drive(VEC[0]);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears", {6'd0, rsp_valid, grant}, 8'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule